// File: doc/BRIEF.md
# Masked Interrupt Flag Register

This block collects eight interrupt sources of a small microcontroller into one sticky status byte. Six of the sources are single-cycle pulses from timers: two pulse-width timer underflows, three auxiliary timer overflows and one main timer overflow. Two are detected inside the block. The first is a falling edge on an external interrupt pin. The second is any change of value on an 8-bit input port. Both of these inputs pass through a two-stage synchronizer before detection.

Software reads and writes three small registers through a simple strobe interface. The status register can only be cleared by software, never set. Reading it returns the flags ANDed with a separate mask register. The interrupt request output is raised whenever a pending flag is also enabled by the mask. A wake-up output is also provided. It fires on a pending port-change flag, or on a comparator event, and each of the two sources has its own enable bit.

Top module: `irq_flag_unit`

## Requirements
- R1: Flag bits are, from bit 7 down to bit 0: low-pulse timer underflow, high-pulse timer underflow, timer C overflow, timer B overflow, timer A overflow, external pin falling edge, port change, main timer overflow. A one-cycle pulse on a timer input sets its flag at the next clock edge.
- R2: Reset clears the flags, the mask and both wake enables. A port value or pin level that is already present when reset is released is not reported as a change or an edge.
- R3: A write to address 0 clears every flag whose write-data bit is 0 and leaves every flag whose bit is 1 unchanged. No write can set a flag, and flags hold until they are cleared.
- R4: When a source event and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R5: Address 0 reads flags AND mask, address 1 reads and writes the mask, address 2 reads and writes the wake enables in bits 1:0 (bit 0 port, bit 1 comparator), and address 3 reads zero.
- R6: A high-to-low transition on the external pin sets bit 2, three clock edges after the change at the pin. A low-to-high transition does not set it.
- R7: A change on any bit of the input port sets bit 1, three clock edges after the change. A steady port sets nothing.
- R8: The interrupt request output is high exactly when some flag is set and its mask bit is 1.
- R9: The wake output is high while the port-change flag is set and the port wake enable (bit 0) is 1, regardless of the mask.
- R10: The wake output follows the comparator event input while the comparator wake enable (bit 1) is 1, and ignores it while that enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register select for read and write |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the selected register (combinational) |
| ext_int_i | input | 1 | External interrupt pin, asynchronous |
| port_i | input | PORT_W | Monitored input port, asynchronous |
| tmr_ovf_i | input | 1 | Main timer overflow pulse |
| aux_ovf_i | input | 3 | Auxiliary timer overflow pulses, bit 0 = A, 1 = B, 2 = C |
| pwt_hi_unf_i | input | 1 | High-pulse width timer underflow pulse |
| pwt_lo_unf_i | input | 1 | Low-pulse width timer underflow pulse |
| cmp_evt_i | input | 1 | Comparator event |
| irq_o | output | 1 | Interrupt request |
| wake_o | output | 1 | Wake-up request |

## Verification
The bench targets a clearing write that lands in the same cycle as a set event. A design where the clear wins would lose that interrupt. It also checks writes of all-ones to an empty register, which a design with a plain load would turn into spurious flags. The cycles after reset release are watched with a non-zero port value and a high pin. A comparison register that is not primed would report a false change or edge there. The bench also checks that a rising pin edge is not taken for a falling one, that wake ignores the mask, and that each wake source stays silent while its enable bit is clear.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;
  localparam int unsigned FLAG_W = 8;

  localparam int unsigned B_MAIN = 0;
  localparam int unsigned B_PORT = 1;
  localparam int unsigned B_EXT  = 2;
  localparam int unsigned B_TA   = 3;
  localparam int unsigned B_TB   = 4;
  localparam int unsigned B_TC   = 5;
  localparam int unsigned B_PWH  = 6;
  localparam int unsigned B_PWL  = 7;

  localparam int unsigned WEN_PORT = 0;
  localparam int unsigned WEN_CMP  = 1;
  localparam int unsigned WEN_W    = 2;

  typedef enum logic [1:0] {
    A_FLAG = 2'd0,
    A_MASK = 2'd1,
    A_WAKE = 2'd2,
    A_NONE = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < int'(STAGES); k++) stg_q[k] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int k = 1; k < int'(STAGES); k++) stg_q[k] <= stg_q[k-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/irq_evt_detect.sv
module irq_evt_detect #(
  parameter int unsigned PORT_W = 8,
  parameter int unsigned ARM_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ext_s_i,
  input  logic [PORT_W-1:0] port_s_i,
  output logic              fall_o,
  output logic              chg_o
);
  // arm_q fills once the synchronizer and the compare registers hold real samples
  logic [ARM_W-1:0]  arm_q;
  logic              ext_prev_q;
  logic [PORT_W-1:0] port_prev_q;
  logic              armed;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_q       <= '0;
      ext_prev_q  <= 1'b0;
      port_prev_q <= '0;
    end else begin
      arm_q       <= {arm_q[ARM_W-2:0], 1'b1};
      ext_prev_q  <= ext_s_i;
      port_prev_q <= port_s_i;
    end
  end

  assign armed  = arm_q[ARM_W-1];
  assign fall_o = armed & ext_prev_q & ~ext_s_i;
  assign chg_o  = armed & (port_prev_q != port_s_i);
endmodule

// File: rtl/irq_flag_reg.sv
module irq_flag_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         clr_en_i,
  input  logic [W-1:0] keep_i,
  output logic [W-1:0] flags_o
);
  logic [W-1:0] flags_q;
  logic [W-1:0] flags_d;

  // a set event overrides a same-cycle clear
  always_comb begin
    flags_d = flags_q;
    if (clr_en_i) flags_d = flags_q & keep_i;
    flags_d = flags_d | set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= flags_d;
  end

  assign flags_o = flags_q;

  a_r3_no_sw_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((flags_q & ~$past(flags_q) & ~$past(set_i)) == '0));

  a_r3_clear_on_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_en_i |=> ((flags_q & ~$past(keep_i) & ~$past(set_i)) == '0));

  a_r4_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((flags_q & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/irq_flag_unit.sv
module irq_flag_unit
  import irq_flag_pkg::*;
#(
  parameter int unsigned PORT_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic              ext_int_i,
  input  logic [PORT_W-1:0] port_i,
  input  logic              tmr_ovf_i,
  input  logic [2:0]        aux_ovf_i,
  input  logic              pwt_hi_unf_i,
  input  logic              pwt_lo_unf_i,
  input  logic              cmp_evt_i,
  output logic              irq_o,
  output logic              wake_o
);
  localparam int unsigned SYNC_W = PORT_W + 1;
  localparam int unsigned ARM_W  = SYNC_STAGES + 1;

  reg_addr_e           addr;
  logic [SYNC_W-1:0]   sync_q;
  logic                fall;
  logic                chg;
  logic [FLAG_W-1:0]   set_vec;
  logic [FLAG_W-1:0]   flag_q;
  logic [FLAG_W-1:0]   mask_q;
  logic [WEN_W-1:0]    wen_q;
  logic [FLAG_W-1:0]   pend;

  assign addr = reg_addr_e'(addr_i);

  irq_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({ext_int_i, port_i}),
    .q_o    (sync_q)
  );

  irq_evt_detect #(.PORT_W(PORT_W), .ARM_W(ARM_W)) u_detect (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ext_s_i  (sync_q[SYNC_W-1]),
    .port_s_i (sync_q[PORT_W-1:0]),
    .fall_o   (fall),
    .chg_o    (chg)
  );

  always_comb begin
    set_vec         = '0;
    set_vec[B_MAIN] = tmr_ovf_i;
    set_vec[B_PORT] = chg;
    set_vec[B_EXT]  = fall;
    set_vec[B_TA]   = aux_ovf_i[0];
    set_vec[B_TB]   = aux_ovf_i[1];
    set_vec[B_TC]   = aux_ovf_i[2];
    set_vec[B_PWH]  = pwt_hi_unf_i;
    set_vec[B_PWL]  = pwt_lo_unf_i;
  end

  irq_flag_reg #(.W(FLAG_W)) u_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (set_vec),
    .clr_en_i (wr_en_i && addr == A_FLAG),
    .keep_i   (wdata_i),
    .flags_o  (flag_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      wen_q  <= '0;
    end else if (wr_en_i) begin
      if (addr == A_MASK) mask_q <= wdata_i;
      if (addr == A_WAKE) wen_q  <= wdata_i[WEN_W-1:0];
    end
  end

  assign pend = flag_q & mask_q;

  always_comb begin
    unique case (addr)
      A_FLAG:  rdata_o = pend;
      A_MASK:  rdata_o = mask_q;
      A_WAKE:  rdata_o = {{(8-WEN_W){1'b0}}, wen_q};
      default: rdata_o = '0;
    endcase
  end

  assign irq_o  = |pend;
  assign wake_o = (wen_q[WEN_PORT] & flag_q[B_PORT]) | (wen_q[WEN_CMP] & cmp_evt_i);

  a_r6_fall_sets_ext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall |=> flag_q[B_EXT]);

  a_r7_change_sets_port: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg |=> flag_q[B_PORT]);

  a_r9_wake_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> (|wen_q));

  a_r2_no_mask_write_no_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && addr == A_MASK) |=> $stable(mask_q));
endmodule

// File: tb/irq_flag_unit_bench.sv
`timescale 1ns/1ps
module irq_flag_unit_bench;
  localparam time CLK_P = 20ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       ext_int = 1'b1;
  logic [7:0] port = 8'hA5;
  logic       tmr = 1'b0;
  logic [2:0] aux = '0;
  logic       pwh = 1'b0;
  logic       pwl = 1'b0;
  logic       cmp = 1'b0;
  logic       irq;
  logic       wake;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  irq_flag_unit u_irq_flag_unit (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .ext_int_i(ext_int), .port_i(port), .tmr_ovf_i(tmr),
    .aux_ovf_i(aux), .pwt_hi_unf_i(pwh), .pwt_lo_unf_i(pwl), .cmp_evt_i(cmp),
    .irq_o(irq), .wake_o(wake)
  );

  // {pulse pattern, mask, expected read}
  localparam logic [23:0] VEC [9] = '{
    {8'h01, 8'hFF, 8'h01}, {8'h08, 8'hFF, 8'h08}, {8'h10, 8'hFF, 8'h10},
    {8'h20, 8'hFF, 8'h20}, {8'h40, 8'hFF, 8'h40}, {8'h80, 8'hFF, 8'h80},
    {8'hF9, 8'h0F, 8'h09}, {8'hF9, 8'hF0, 8'hF0}, {8'h89, 8'h00, 8'h00}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic pulse(input logic [7:0] p);
    @(negedge clk);
    pwl = p[7]; pwh = p[6]; aux = p[5:3]; tmr = p[0];
    @(negedge clk);
    pwl = 1'b0; pwh = 1'b0; aux = '0; tmr = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 200000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    idle(3);
    rst_n = 1'b1;
    idle(6);
    // R2: reset values, no false change from pre-existing port and pin levels
    rd(2'd1, d); chk("R2 mask reset", d, 8'h00);
    rd(2'd2, d); chk("R2 wake enable reset", d, 8'h00);
    chk("R2 irq reset", {7'b0, irq}, 8'h00);
    chk("R2 wake reset", {7'b0, wake}, 8'h00);
    wr(2'd1, 8'hFF);
    rd(2'd0, d); chk("R2 no false change", d, 8'h00);
    // R5: register readback
    rd(2'd1, d); chk("R5 mask readback", d, 8'hFF);
    wr(2'd2, 8'hFE);
    rd(2'd2, d); chk("R5 wake readback", d, 8'h02);
    rd(2'd3, d); chk("R5 unused address", d, 8'h00);
    wr(2'd2, 8'h00);

    // R1 R8: table walk
    foreach (VEC[i]) begin
      wr(2'd1, VEC[i][15:8]);
      pulse(VEC[i][23:16]);
      rd(2'd0, d); chk("R1 masked flags", d, VEC[i][7:0]);
      chk("R8 irq", {7'b0, irq}, {7'b0, |VEC[i][7:0]});
      wr(2'd0, 8'h00);
      wr(2'd1, 8'hFF);
      rd(2'd0, d); chk("R3 cleared after vector", d, 8'h00);
    end

    // R3: selective clear, write of ones keeps, write cannot set
    pulse(8'hF9);
    wr(2'd0, 8'hF0);
    rd(2'd0, d); chk("R3 clear on zero", d, 8'hF0);
    wr(2'd0, 8'hFF);
    rd(2'd0, d); chk("R3 ones keep", d, 8'hF0);
    idle(5);
    rd(2'd0, d); chk("R3 sticky", d, 8'hF0);
    wr(2'd0, 8'h00);
    wr(2'd0, 8'hFF);
    rd(2'd0, d); chk("R3 no software set", d, 8'h00);

    // R4: set beats clear in same cycle
    pulse(8'hF8);
    @(negedge clk);
    wr_en = 1'b1; addr = 2'd0; wdata = 8'h00; tmr = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tmr = 1'b0;
    rd(2'd0, d); chk("R4 set wins", d, 8'h01);
    wr(2'd0, 8'h00);

    // R6: rising edge ignored, falling edge sets bit 2
    @(negedge clk); ext_int = 1'b0;
    idle(4);
    wr(2'd0, 8'h00);
    @(negedge clk); ext_int = 1'b1;
    idle(4);
    rd(2'd0, d); chk("R6 rising ignored", d, 8'h00);
    @(negedge clk); ext_int = 1'b0;
    idle(2);
    rd(2'd0, d); chk("R6 not yet", d, 8'h00);
    idle(1);
    rd(2'd0, d); chk("R6 falling sets", d, 8'h04);
    wr(2'd0, 8'h00);

    // R7: steady port, then single-bit change
    idle(5);
    rd(2'd0, d); chk("R7 steady port", d, 8'h00);
    @(negedge clk); port = 8'hA4;
    idle(3);
    rd(2'd0, d); chk("R7 change sets", d, 8'h02);

    // R9: port wake gated by enable, independent of mask
    wr(2'd1, 8'h00);
    #1; chk("R9 wake off without enable", {7'b0, wake}, 8'h00);
    chk("R8 irq masked", {7'b0, irq}, 8'h00);
    wr(2'd2, 8'h01);
    #1; chk("R9 wake with enable", {7'b0, wake}, 8'h01);
    wr(2'd0, 8'h00);
    #1; chk("R9 wake drops on clear", {7'b0, wake}, 8'h00);

    // R10: comparator wake
    @(negedge clk); cmp = 1'b1;
    #1; chk("R10 comparator ignored", {7'b0, wake}, 8'h00);
    cmp = 1'b0;
    wr(2'd2, 8'h02);
    @(negedge clk); cmp = 1'b1;
    #1; chk("R10 comparator wakes", {7'b0, wake}, 8'h01);
    cmp = 1'b0;
    #1; chk("R10 comparator released", {7'b0, wake}, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule